// File: doc/BRIEF.md
# Sliding-Window Class Score Accumulator

This block turns a stream of dictionary indices, one per accepted event, into a running per-class score for a linear classifier. Each class has a signed accumulator. When an index arrives, the weight that index carries for every class is added to the matching accumulator. No multiplier is used, because the dot product of a weight matrix with a match histogram reduces to summing the rows that the events select.

To restrict the scores to the most recent `WIN_DEPTH` events, every accepted index is also stored in a circular window. Once the window holds `WIN_DEPTH` entries, a new event evicts the oldest one. The evicted index's weights are subtracted in the same clock edge that adds the new index's weights. As a result, the scores always equal the classifier output over at most the last `WIN_DEPTH` events.

The block also reports the winning class, meaning the highest score with the lowest class number on ties, for the current register contents. The weights are generated by a fixed arithmetic rule, so no memory initialisation file is needed. A synchronous clear input restarts the window.

Top module: `window_class_acc`

## Requirements
- R1: After reset every class score is zero and `best_o` is 0.
- R2: The weight of dictionary index i for class c is ((i*29 + c*71) mod 2^WEIGHT_W) - 2^(WEIGHT_W-1), as a signed WEIGHT_W-bit value.
- R3: While fewer than WIN_DEPTH events are held, an accepted event (`valid_i`=1, `clear_i`=0) adds its weights to every class score, and the result is visible right after the capturing clock edge.
- R4: When WIN_DEPTH events are already held, an accepted event adds its own weights and subtracts the weights of the oldest held event in one update. The scores therefore always equal the weight sums of the last min(n, WIN_DEPTH) accepted events.
- R5: In a cycle with `valid_i`=0 and `clear_i`=0, all scores stay unchanged.
- R6: `best_o` is the class number whose score is largest, with the lowest number winning ties. It reflects the registered scores, so it changes in the same cycle as the scores, one clock after the input.
- R7: `clear_i`=1 zeroes all scores and empties the window at the next edge. An event presented in the same cycle is discarded.
- R8: Each score is WEIGHT_W + clog2(WIN_DEPTH+1) bits wide. A full window of the most negative weight is held without wrap-around.
- R9: `scores_o` packs class c, in two's complement, at bits [c*ACC_W +: ACC_W], where ACC_W is the score width from R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of the scores and the window |
| valid_i | input | 1 | An event index is present this cycle |
| index_i | input | IDX_W | Dictionary index of the event |
| scores_o | output | NUM_CLASSES*ACC_W | Packed signed score per class |
| best_o | output | max(1,clog2(NUM_CLASSES)) | Winning class number |

## Verification
The bench builds the block with four classes, a 16-entry dictionary, 8-bit weights and a window of only five events. The short window lets eviction and pointer wrap-around occur many times in a run of a few hundred events. It also lets five repeats of index 0, whose class-0 weight is -128, drive class 0 to -640. That value is the extreme the 11-bit score must hold. Runs of identical scores after a clear exercise the tie rule, and a clear issued together with an event exercises the clear-over-event rule.

// File: rtl/wca_pkg.sv
package wca_pkg;
  // Strobes issued by the window control to the score datapath
  typedef struct packed {
    logic clear;  // zero scores, window restarts
    logic push;   // accept event, add its weights
    logic pop;    // window full, subtract oldest weights
  } ctrl_strb_t;
endpackage

// File: rtl/wca_weight_rom.sv
module wca_weight_rom #(
  parameter int NUM_CLASSES = 4,
  parameter int IDX_W       = 10,
  parameter int WEIGHT_W    = 12
) (
  input  logic [IDX_W-1:0]                idx,
  output logic [NUM_CLASSES*WEIGHT_W-1:0] wts
);
  // Arithmetic weight table: ((idx*29 + c*71) mod 2^W) - 2^(W-1)
  always_comb begin
    for (int c = 0; c < NUM_CLASSES; c++) begin
      logic [31:0] raw;
      raw = 32'(idx) * 32'd29 + 32'(c) * 32'd71;
      // subtracting half range equals inverting the top bit
      wts[c*WEIGHT_W +: WEIGHT_W] = {~raw[WEIGHT_W-1], raw[WEIGHT_W-2:0]};
    end
  end
endmodule

// File: rtl/wca_ctrl.sv
module wca_ctrl
  import wca_pkg::*;
#(
  parameter int WIN_DEPTH = 256,
  parameter int PTR_W     = 8,
  parameter int CNT_W     = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clearIn,
  input  logic             validIn,
  output ctrl_strb_t       strb,
  output logic [PTR_W-1:0] wrPtr
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WIN_DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(WIN_DEPTH - 1);

  logic [CNT_W-1:0] fillCnt;
  logic             isFull;

  assign isFull     = (fillCnt == FULL_CNT);
  assign strb.clear = clearIn;
  assign strb.push  = validIn & ~clearIn;
  assign strb.pop   = validIn & ~clearIn & isFull;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fillCnt <= '0;
      wrPtr   <= '0;
    end else if (strb.clear) begin
      fillCnt <= '0;
      wrPtr   <= '0;
    end else if (strb.push) begin
      wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (!isFull) fillCnt <= fillCnt + 1'b1;
    end
  end

  // R4
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fillCnt <= FULL_CNT);

  // R4
  evict_with_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.pop |-> (strb.push && !strb.clear));

  // R7
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clear |=> (fillCnt == '0 && wrPtr == '0));
endmodule

// File: rtl/wca_datapath.sv
module wca_datapath
  import wca_pkg::*;
#(
  parameter int NUM_CLASSES = 4,
  parameter int IDX_W       = 10,
  parameter int WIN_DEPTH   = 256,
  parameter int WEIGHT_W    = 12,
  parameter int ACC_W       = 21,
  parameter int PTR_W       = 8,
  parameter int CLS_W       = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  ctrl_strb_t                   strb,
  input  logic [PTR_W-1:0]             wrPtr,
  input  logic [IDX_W-1:0]             index,
  output logic [NUM_CLASSES*ACC_W-1:0] scores,
  output logic [CLS_W-1:0]             best
);
  logic [IDX_W-1:0]                winMem [WIN_DEPTH];
  logic [IDX_W-1:0]                oldIdx;
  logic [NUM_CLASSES*WEIGHT_W-1:0] addWts;
  logic [NUM_CLASSES*WEIGHT_W-1:0] subWts;
  logic signed [ACC_W-1:0]         score [NUM_CLASSES];

  // Oldest entry sits at the write pointer once the window is full
  assign oldIdx = winMem[wrPtr];

  always_ff @(posedge clk) begin
    if (strb.push) winMem[wrPtr] <= index;
  end

  wca_weight_rom #(.NUM_CLASSES(NUM_CLASSES), .IDX_W(IDX_W), .WEIGHT_W(WEIGHT_W))
    i_add_rom (.idx(index), .wts(addWts));

  wca_weight_rom #(.NUM_CLASSES(NUM_CLASSES), .IDX_W(IDX_W), .WEIGHT_W(WEIGHT_W))
    i_sub_rom (.idx(oldIdx), .wts(subWts));

  for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_cls
    logic signed [WEIGHT_W-1:0] wAdd, wSub;
    logic signed [ACC_W-1:0]    addTerm, subTerm;

    assign wAdd    = addWts[g*WEIGHT_W +: WEIGHT_W];
    assign wSub    = subWts[g*WEIGHT_W +: WEIGHT_W];
    assign addTerm = strb.push ? ACC_W'(wAdd) : '0;
    assign subTerm = strb.pop  ? ACC_W'(wSub) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          score[g] <= '0;
      else if (strb.clear) score[g] <= '0;
      else                 score[g] <= score[g] + addTerm - subTerm;
    end

    assign scores[g*ACC_W +: ACC_W] = score[g];

    // R7
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strb.clear |=> (score[g] == '0));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!strb.push && !strb.clear) |=> $stable(score[g]));
  end

  // Argmax, strict compare keeps the lowest class on ties
  always_comb begin
    best = '0;
    for (int c = 1; c < NUM_CLASSES; c++) begin
      if (score[c] > score[best]) best = CLS_W'(c);
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NUM_CLASSES; c++) begin
        if (c < int'(best)) begin
          // R6
          argmax_tie_chk: assert (score[c] < score[best]);
        end else begin
          // R6
          argmax_max_chk: assert (score[c] <= score[best]);
        end
      end
    end
  end
endmodule

// File: rtl/window_class_acc.sv
module window_class_acc
  import wca_pkg::*;
#(
  parameter int NUM_CLASSES = 4,
  parameter int IDX_W       = 10,
  parameter int WIN_DEPTH   = 256,
  parameter int WEIGHT_W    = 12,
  localparam int ACC_W      = WEIGHT_W + $clog2(WIN_DEPTH + 1),
  localparam int CLS_W      = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear_i,
  input  logic                         valid_i,
  input  logic [IDX_W-1:0]             index_i,
  output logic [NUM_CLASSES*ACC_W-1:0] scores_o,
  output logic [CLS_W-1:0]             best_o
);
  localparam int PTR_W = (WIN_DEPTH > 1) ? $clog2(WIN_DEPTH) : 1;
  localparam int CNT_W = $clog2(WIN_DEPTH + 1);

  ctrl_strb_t       strb;
  logic [PTR_W-1:0] wrPtr;

  wca_ctrl #(.WIN_DEPTH(WIN_DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .clearIn(clear_i), .validIn(valid_i),
    .strb(strb), .wrPtr(wrPtr)
  );

  wca_datapath #(
    .NUM_CLASSES(NUM_CLASSES), .IDX_W(IDX_W), .WIN_DEPTH(WIN_DEPTH),
    .WEIGHT_W(WEIGHT_W), .ACC_W(ACC_W), .PTR_W(PTR_W), .CLS_W(CLS_W)
  ) i_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrPtr(wrPtr), .index(index_i),
    .scores(scores_o), .best(best_o)
  );
endmodule

// File: tb/test_window_class_acc.sv
module test_window_class_acc;
  localparam int NC  = 4;
  localparam int IW  = 4;
  localparam int WIN = 5;
  localparam int WW  = 8;
  localparam int AW  = WW + $clog2(WIN + 1);

  logic clk = 0, rst_n = 0, clr = 0, vld = 0;
  logic [IW-1:0] idx = '0;
  logic [NC*AW-1:0] scores;
  logic [1:0] best;

  always #2 clk = ~clk;

  window_class_acc #(.NUM_CLASSES(NC), .IDX_W(IW), .WIN_DEPTH(WIN), .WEIGHT_W(WW))
    i_window_class_acc (.clk(clk), .rst_n(rst_n), .clear_i(clr), .valid_i(vld),
                        .index_i(idx), .scores_o(scores), .best_o(best));

  typedef struct { int s[NC]; int b; string tag; } exp_t;
  exp_t expQ[$];
  exp_t cur;
  int   model[NC];
  int   winQ[$];
  int   checks = 0, errors = 0;
  bit   done = 0;

  // R2 weight rule, computed arithmetically
  function automatic int wgt(int i, int c);
    return ((i * 29 + c * 71) % (1 << WW)) - (1 << (WW - 1));
  endfunction

  function automatic int argmax();
    int b = 0;
    for (int c = 1; c < NC; c++) if (model[c] > model[b]) b = c;
    return b;
  endfunction

  function automatic int scoreOut(int c);
    return int'($signed(scores[c*AW +: AW]));
  endfunction

  task automatic expectNow(string tag);
    exp_t e;
    for (int c = 0; c < NC; c++) e.s[c] = model[c];
    e.b = argmax();
    e.tag = tag;
    expQ.push_back(e);
  endtask

  // Driver: one cycle per call, expectation queued before the edge
  task automatic step(bit v, bit c, int i, string tag);
    @(negedge clk);
    vld = v; clr = c; idx = IW'(i);
    if (c) begin
      winQ.delete();
      for (int k = 0; k < NC; k++) model[k] = 0;
    end else if (v) begin
      if (winQ.size() == WIN) begin
        int old = winQ.pop_front();
        for (int k = 0; k < NC; k++) model[k] -= wgt(old, k);
      end
      winQ.push_back(i);
      for (int k = 0; k < NC; k++) model[k] += wgt(i, k);
    end
    expectNow(tag);
  endtask

  // Monitor: compare just after each edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      cur = expQ.pop_front();
      for (int c = 0; c < NC; c++) begin
        checks++;
        if (scoreOut(c) != cur.s[c]) begin
          errors++;
          $display("FAIL %s class %0d score actual %0d expected %0d", cur.tag, c, scoreOut(c), cur.s[c]);
        end
      end
      checks++;
      if (int'(best) != cur.b) begin
        errors++;
        $display("FAIL %s R6 best actual %0d expected %0d", cur.tag, best, cur.b);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lcg = 7;
    for (int k = 0; k < NC; k++) model[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    for (int c = 0; c < NC; c++) begin
      checks++;
      if (scoreOut(c) != 0) begin
        errors++;
        $display("FAIL R1 class %0d actual %0d expected 0", c, scoreOut(c));
      end
    end
    checks++;
    if (best != 0) begin errors++; $display("FAIL R1 best actual %0d expected 0", best); end

    // R3 partial window, R2 weights
    step(1, 0, 3, "R3");
    step(1, 0, 9, "R3_R2");
    step(1, 0, 14, "R3");
    // R5 idle
    step(0, 0, 5, "R5");
    step(0, 0, 1, "R5");
    step(1, 0, 7, "R3");
    step(1, 0, 2, "R3");
    // R4 sliding window with eviction
    for (int n = 0; n < 12; n++) step(1, 0, (n * 5 + 1) % 16, "R4");
    // R7 clear with simultaneous event, then R6 tie at zero
    step(1, 1, 11, "R7");
    step(0, 0, 0, "R6_tie");
    // R8 extreme: index 0 gives class 0 weight -128
    for (int n = 0; n < WIN + 3; n++) step(1, 0, 0, "R8");
    // R9 and R4 long mixed stream
    for (int n = 0; n < 300; n++) begin
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      step((lcg >> 8) % 4 != 0, (lcg >> 12) % 61 == 0, (lcg >> 16) % 16, "R4_R9");
    end
    step(0, 0, 0, "R5");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule